// File: doc/BRIEF.md
# Comparator Interrupt Flag and Vector Controller

This block turns the conditioned output of an analog comparator and its ready strobe into three latched interrupt sources: one for the output edge, one for the opposite-polarity output edge, and one for comparator ready. One edge-select input sets which direction of output transition goes to which of the two edge flags. Each source has a flag and an enable, and all six bits sit in a 16-bit control word at byte offset 0xC of a small register bus.

A read-only 16-bit vector word at offset 0xE reports the highest-priority source whose flag and enable are both set. Reading it acknowledges that source by clearing its flag alone. The block drives one interrupt request line, which is high whenever any enabled flag is set. Edges are found by comparing the comparator input with a registered copy of its value in the previous cycle. A flag set by an edge or by the ready strobe is visible from the cycle after the edge is sampled.

Top module: `cmpirq_ctrl`

## Requirements
- R1: While reset is low and right after it, the control word at 0xC reads 0x0000, the vector word at 0xE reads 0x0000 and `irq` is low.
- R2: The control word holds the output-edge flag at bit 0, the inverted flag at bit 1 and the ready flag at bit 4, with their enables at bits 8, 9 and 12. A write to 0xC loads all six bits, and the other ten bits always read 0.
- R3: With `edge_sel` = 0, a low-to-high change of `cmp_out` sets the output-edge flag and a high-to-low change sets the inverted flag, both visible one cycle after the sampling edge.
- R4: With `edge_sel` = 1, a high-to-low change of `cmp_out` sets the output-edge flag and a low-to-high change sets the inverted flag.
- R5: A cycle with `rdy_pulse` high sets the ready flag.
- R6: The vector word reads 2 when the output-edge source is pending, 4 when the inverted source is pending, 10 when the ready source is pending and 0 when none is. When several are pending it reports the output-edge source before the inverted source, and the inverted source before the ready source.
- R7: A source is pending only when its flag and its enable are both 1. `irq` is high exactly when at least one source is pending.
- R8: A read of the vector word clears the flag of the source it reports and leaves every other flag and every enable unchanged. A read that returns 0 changes nothing.
- R9: A flag-set event in the same cycle as a control-word write of 0 to that flag, or as a vector read that reports that flag, leaves the flag set.
- R10: The vector word is read-only. Writes to 0xE, and reads or writes at any offset other than 0xC and 0xE, change no flag or enable, and such reads return 0.
- R11: The first sampled cycle after reset never counts as a `cmp_out` edge, whatever level `cmp_out` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmp_out | input | 1 | Conditioned comparator output level |
| rdy_pulse | input | 1 | Comparator ready strobe, one cycle per event |
| edge_sel | input | 1 | Edge-to-flag mapping select |
| req_en | input | 1 | Bus access strobe |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte offset of the access |
| req_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data, valid in the same cycle as a read access |
| irq | output | 1 | Combined interrupt request |

## Verification
Two functions can act on the same flag in the same cycle. A hardware set from an edge or a ready strobe can coincide with a software clear, either from a control-word write of 0 or from a vector read that acknowledges that flag. Directed cycles place a `cmp_out` transition on the same edge as a clearing write, and a ready strobe on the same edge as the vector read that reports the ready flag. Random traffic then mixes strobes, toggles and bus accesses freely. In each case the bench judges the result by reading the control word back and comparing it with a reference model in which the set wins.

// File: rtl/cmpirq_pkg.sv
`timescale 1ns/1ps
package cmpirq_pkg;
  localparam int NSRC     = 3;
  localparam int EN_SHIFT = 8;

  typedef enum logic [1:0] {
    SRC_OUT = 2'd0,
    SRC_INV = 2'd1,
    SRC_RDY = 2'd2
  } src_e;

  // bit position of each source flag in the control word (decoded by software)
  function automatic int flag_bit(input int idx);
    case (idx)
      0:       return 0;
      1:       return 1;
      default: return 4;
    endcase
  endfunction

  // code the vector word returns for each source
  function automatic int vec_code(input int idx);
    case (idx)
      0:       return 2;
      1:       return 4;
      default: return 10;
    endcase
  endfunction
endpackage

// File: rtl/cmpirq_edge_det.sv
`timescale 1ns/1ps
module cmpirq_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  input  logic edge_sel,
  output logic set_out,
  output logic set_inv,
  output logic prev_q,
  output logic armed_q
);
  logic prev_d;
  logic armed_d;
  logic rise;
  logic fall;

  always_comb begin
    rise    = armed_q & sig_in & ~prev_q;
    fall    = armed_q & ~sig_in & prev_q;
    set_out = edge_sel ? fall : rise;
    set_inv = edge_sel ? rise : fall;
    prev_d  = sig_in;
    armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/cmpirq_flag_bank.sv
`timescale 1ns/1ps
module cmpirq_flag_bank #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] hw_set,
  input  logic [NSRC-1:0] ack_clr,
  input  logic            sw_wr,
  input  logic [NSRC-1:0] sw_flag,
  input  logic [NSRC-1:0] sw_en,
  output logic [NSRC-1:0] flag_q,
  output logic [NSRC-1:0] en_q
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic flag_d;
    logic en_d;
    logic en_ce;

    always_comb begin
      // a hardware set overrides any clear from software
      if (hw_set[g])        flag_d = 1'b1;
      else if (sw_wr)       flag_d = sw_flag[g];
      else if (ack_clr[g])  flag_d = 1'b0;
      else                  flag_d = flag_q[g];
      en_ce = sw_wr;
      en_d  = sw_en[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[g] <= 1'b0;
      end else begin
        flag_q[g] <= flag_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[g] <= 1'b0;
      end else if (en_ce) begin
        en_q[g] <= en_d;
      end
    end
  end
endmodule

// File: rtl/cmpirq_vec_enc.sv
`timescale 1ns/1ps
module cmpirq_vec_enc
  import cmpirq_pkg::*;
#(
  parameter int NSRC = 3,
  parameter int DW   = 16
) (
  input  logic [NSRC-1:0] pend,
  output logic [DW-1:0]   vec,
  output logic [NSRC-1:0] win,
  output logic            any
);
  always_comb begin
    vec = '0;
    win = '0;
    // walk from lowest priority up so the highest priority source is kept
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        vec    = DW'(vec_code(i));
        win    = '0;
        win[i] = 1'b1;
      end
    end
    any = |pend;
  end
endmodule

// File: rtl/cmpirq_ctrl.sv
`timescale 1ns/1ps
module cmpirq_ctrl
  import cmpirq_pkg::*;
#(
  parameter int          DW      = 16,
  parameter int          AW      = 4,
  parameter logic [3:0]  CTL_OFF = 4'hC,
  parameter logic [3:0]  VEC_OFF = 4'hE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_out,
  input  logic          rdy_pulse,
  input  logic          edge_sel,
  input  logic          req_en,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  localparam logic [AW-1:0] CTL_A = AW'(CTL_OFF);
  localparam logic [AW-1:0] VEC_A = AW'(VEC_OFF);

  logic            set_out;
  logic            set_inv;
  logic            prev_q;
  logic            armed_q;
  logic [NSRC-1:0] hw_set;
  logic [NSRC-1:0] ack_clr;
  logic [NSRC-1:0] sw_flag;
  logic [NSRC-1:0] sw_en;
  logic [NSRC-1:0] flag_q;
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] win;
  logic [DW-1:0]   vec;
  logic [DW-1:0]   ctl_word;
  logic            any;
  logic            hit_ctl;
  logic            hit_vec;
  logic            wr_ctl;
  logic            rd_vec;
  logic            rd_any;

  cmpirq_edge_det u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .sig_in   (cmp_out),
    .edge_sel (edge_sel),
    .set_out  (set_out),
    .set_inv  (set_inv),
    .prev_q   (prev_q),
    .armed_q  (armed_q)
  );

  always_comb begin
    hit_ctl = req_en & (req_addr == CTL_A);
    hit_vec = req_en & (req_addr == VEC_A);
    wr_ctl  = hit_ctl & req_wr;
    rd_vec  = hit_vec & ~req_wr;
    rd_any  = req_en & ~req_wr;
    hw_set  = '0;
    hw_set[SRC_OUT] = set_out;
    hw_set[SRC_INV] = set_inv;
    hw_set[SRC_RDY] = rdy_pulse;
    ack_clr = rd_vec ? win : '0;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_wmap
    assign sw_flag[g] = req_wdata[flag_bit(g)];
    assign sw_en[g]   = req_wdata[flag_bit(g) + EN_SHIFT];
  end

  cmpirq_flag_bank #(.NSRC(NSRC)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_set  (hw_set),
    .ack_clr (ack_clr),
    .sw_wr   (wr_ctl),
    .sw_flag (sw_flag),
    .sw_en   (sw_en),
    .flag_q  (flag_q),
    .en_q    (en_q)
  );

  assign pend = flag_q & en_q;

  cmpirq_vec_enc #(.NSRC(NSRC), .DW(DW)) u_enc (
    .pend (pend),
    .vec  (vec),
    .win  (win),
    .any  (any)
  );

  always_comb begin
    ctl_word = '0;
    for (int i = 0; i < NSRC; i++) begin
      ctl_word[flag_bit(i)]            = flag_q[i];
      ctl_word[flag_bit(i) + EN_SHIFT] = en_q[i];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_any && hit_ctl)      rd_data = ctl_word;
    else if (rd_any && hit_vec) rd_data = vec;
  end

  assign irq = any;
endmodule

// File: rtl/cmpirq_ctrl_chk.sv
`timescale 1ns/1ps
module cmpirq_ctrl_chk #(
  parameter int          NSRC    = 3,
  parameter int          DW      = 16,
  parameter int          AW      = 4,
  parameter logic [3:0]  VEC_OFF = 4'hE
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmp_out,
  input logic            rdy_pulse,
  input logic            edge_sel,
  input logic            req_en,
  input logic            req_wr,
  input logic [AW-1:0]   req_addr,
  input logic [DW-1:0]   req_wdata,
  input logic [DW-1:0]   rd_data,
  input logic            irq,
  input logic [NSRC-1:0] flag_q,
  input logic [NSRC-1:0] en_q,
  input logic            prev_q,
  input logic            armed_q
);
  logic up_edge;
  logic dn_edge;
  logic vec_rd;
  logic vec_wr;

  assign up_edge = armed_q & cmp_out & ~prev_q;
  assign dn_edge = armed_q & ~cmp_out & prev_q;
  assign vec_rd  = req_en & ~req_wr & (req_addr == AW'(VEC_OFF));
  assign vec_wr  = req_en & req_wr & (req_addr == AW'(VEC_OFF));

  AST_RISE_SEL0: assert property (@(posedge clk) disable iff (!rst_n)
    (up_edge && !edge_sel) |=> flag_q[0]);                        // R3
  AST_FALL_SEL0: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_edge && !edge_sel) |=> flag_q[1]);                        // R3
  AST_FALL_SEL1: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_edge && edge_sel) |=> flag_q[0]);                         // R4
  AST_RISE_SEL1: assert property (@(posedge clk) disable iff (!rst_n)
    (up_edge && edge_sel) |=> flag_q[1]);                         // R4
  AST_RDY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_pulse |=> flag_q[2]);                                     // R5
  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    vec_rd |-> (rd_data == 0 || rd_data == 2 || rd_data == 4 || rd_data == 10)); // R6
  AST_IRQ_VS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    vec_rd |-> ((rd_data != 0) == irq));                          // R7
  AST_ACK_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && rd_data == 2 && !(up_edge && !edge_sel) && !(dn_edge && edge_sel))
      |=> !flag_q[0]);                                            // R8
  AST_ACK_KEEP_EN: assert property (@(posedge clk) disable iff (!rst_n)
    vec_rd |=> $stable(en_q));                                    // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_pulse && req_en && req_wr && !vec_wr) |=> flag_q[2]);     // R9
  AST_VEC_RO: assert property (@(posedge clk) disable iff (!rst_n)
    vec_wr |=> $stable(en_q));                                    // R10
  AST_NO_FIRST_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !rdy_pulse && !(req_en && req_wr)) |=> (flag_q == '0)); // R11
endmodule

bind cmpirq_ctrl cmpirq_ctrl_chk #(
  .NSRC(cmpirq_pkg::NSRC), .DW(DW), .AW(AW), .VEC_OFF(VEC_OFF)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmp_out   (cmp_out),
  .rdy_pulse (rdy_pulse),
  .edge_sel  (edge_sel),
  .req_en    (req_en),
  .req_wr    (req_wr),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rd_data   (rd_data),
  .irq       (irq),
  .flag_q    (flag_q),
  .en_q      (en_q),
  .prev_q    (prev_q),
  .armed_q   (armed_q)
);

// File: tb/cmpirq_ctrl_bench.sv
`timescale 1ns/1ps
module cmpirq_ctrl_bench;
  logic        clk;
  logic        rst_n;
  logic        cmp;
  logic        rdy;
  logic        esel;
  logic        ren;
  logic        rwr;
  logic [3:0]  raddr;
  logic [15:0] rwd;
  logic [15:0] rd_data;
  logic        irq;

  int n_cmp;
  int n_bad;

  // reference model state
  logic [2:0] mf;
  logic [2:0] me;
  logic       mprev;
  logic       marmed;

  cmpirq_ctrl u_cmpirq_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_out   (cmp),
    .rdy_pulse (rdy),
    .edge_sel  (esel),
    .req_en    (ren),
    .req_wr    (rwr),
    .req_addr  (raddr),
    .req_wdata (rwd),
    .rd_data   (rd_data),
    .irq       (irq)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  function automatic logic [15:0] exp_ctl();
    logic [15:0] w = '0;
    w[0] = mf[0]; w[1] = mf[1]; w[4] = mf[2];
    w[8] = me[0]; w[9] = me[1]; w[12] = me[2];
    return w;
  endfunction

  function automatic logic [15:0] exp_vec();
    logic [2:0] p = mf & me;
    if (p[0]) return 16'd2;
    if (p[1]) return 16'd4;
    if (p[2]) return 16'd10;
    return 16'd0;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    mf = '0; me = '0; mprev = 1'b0; marmed = 1'b0;
  endtask

  // one clock: check outputs before the edge, advance model, move to next negedge
  task automatic tick(input string tag);
    logic [15:0] v;
    logic [2:0]  set;
    logic [2:0]  clr;
    logic        rise;
    logic        fall;
    #1;
    if (rst_n) check({tag, " irq"}, {15'd0, irq}, {15'd0, |(mf & me)});
    else       check({tag, " irq"}, {15'd0, irq}, 16'd0);
    if (ren && !rwr) begin
      if (!rst_n)              v = 16'd0;
      else if (raddr == 4'hC)  v = exp_ctl();
      else if (raddr == 4'hE)  v = exp_vec();
      else                     v = 16'd0;
      check(tag, rd_data, v);
    end
    if (rst_n) begin
      rise = marmed & cmp & ~mprev;
      fall = marmed & ~cmp & mprev;
      set  = {rdy, esel ? rise : fall, esel ? fall : rise};
      clr  = '0;
      if (ren && !rwr && raddr == 4'hE) begin
        v = exp_vec();
        if (v == 16'd2)       clr[0] = 1'b1;
        else if (v == 16'd4)  clr[1] = 1'b1;
        else if (v == 16'd10) clr[2] = 1'b1;
      end
      if (ren && rwr && raddr == 4'hC) begin
        mf = set | {rwd[4], rwd[1], rwd[0]};
        me = {rwd[12], rwd[9], rwd[8]};
      end else begin
        mf = set | (mf & ~clr);
      end
      mprev  = cmp;
      marmed = 1'b1;
    end else begin
      model_reset();
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_idle();
    ren = 1'b0; rwr = 1'b0; raddr = 4'h0; rwd = 16'h0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input string tag);
    ren = 1'b1; rwr = 1'b1; raddr = a; rwd = d;
    tick(tag);
    bus_idle();
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    ren = 1'b1; rwr = 1'b0; raddr = a; rwd = 16'h0;
    tick(tag);
    bus_idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    n_cmp = 0;
    n_bad = 0;
    model_reset();
    rst_n = 1'b0;
    cmp = 1'b1; rdy = 1'b0; esel = 1'b0;
    bus_idle();
    @(negedge clk);
    // R1: reset state
    rd(4'hC, "R1");
    rd(4'hE, "R1");
    rst_n = 1'b1;
    // R11: cmp is already high at release, no edge recorded
    tick("R11");
    wr(4'hC, 16'h1300, "R11");
    rd(4'hC, "R11");
    rd(4'hE, "R1");
    // R3: edge_sel 0
    cmp = 1'b0; tick("R3");
    rd(4'hC, "R3");
    rd(4'hE, "R3");
    cmp = 1'b1; tick("R3");
    rd(4'hE, "R3");
    rd(4'hC, "R3");
    // R4: edge_sel 1
    esel = 1'b1;
    cmp = 1'b0; tick("R4");
    rd(4'hC, "R4");
    rd(4'hE, "R4");
    cmp = 1'b1; tick("R4");
    rd(4'hE, "R4");
    // R5: ready strobe
    rdy = 1'b1; tick("R5"); rdy = 1'b0;
    rd(4'hC, "R5");
    rd(4'hE, "R5");
    // R6 and R8: all three pending, acknowledged in priority order
    esel = 1'b0;
    rdy = 1'b1; cmp = 1'b0; tick("R6"); rdy = 1'b0;
    cmp = 1'b1; tick("R6");
    rd(4'hC, "R6");
    rd(4'hE, "R8"); rd(4'hC, "R8");
    rd(4'hE, "R6"); rd(4'hE, "R6"); rd(4'hE, "R6");
    // R7: flags without enables are not pending
    wr(4'hC, 16'h0013, "R7");
    rd(4'hE, "R7");
    wr(4'hC, 16'h0213, "R7");
    rd(4'hE, "R7");
    // R2: unused bits read 0
    wr(4'hC, 16'hFFFF, "R2");
    rd(4'hC, "R2");
    // R9: edge in the same cycle as a clearing write
    wr(4'hC, 16'h1300, "R9");
    cmp = 1'b0; tick("R9");
    wr(4'hC, 16'h1300, "R9");
    cmp = 1'b1; wr(4'hC, 16'h1300, "R9");
    rd(4'hC, "R9");
    // R9: ready strobe in the same cycle as the vector read that reports it
    wr(4'hC, 16'h1010, "R9");
    rdy = 1'b1; rd(4'hE, "R9"); rdy = 1'b0;
    rd(4'hC, "R9");
    // R10: vector word and unmapped offsets are inert
    wr(4'hC, 16'h0100, "R10");
    wr(4'hE, 16'hFFFF, "R10");
    wr(4'h3, 16'hFFFF, "R10");
    rd(4'hC, "R10");
    rd(4'h3, "R10");

    // random phase
    void'($urandom(32'h5EED_C0DE));
    for (int n = 0; n < 4000; n++) begin
      int r;
      string tag;
      if ($urandom % 3 == 0) cmp = ~cmp;
      rdy = ($urandom % 8 == 0);
      if ($urandom % 40 == 0) esel = ~esel;
      r = $urandom % 10;
      bus_idle();
      tag = "R7";
      if (r < 2) begin
        ren = 1'b1; rwr = ($urandom % 3 == 0); raddr = 4'hC; rwd = 16'($urandom); tag = "R2";
      end else if (r < 5) begin
        ren = 1'b1; rwr = ($urandom % 6 == 0); raddr = 4'hE; rwd = 16'($urandom); tag = "R6";
      end else if (r < 6) begin
        ren = 1'b1; rwr = $urandom % 2; raddr = 4'($urandom); rwd = 16'($urandom); tag = "R10";
      end
      tick(tag);
    end
    bus_idle();
    rdy = 1'b0;
    rd(4'hC, "R2");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule